// File: doc/BRIEF.md
# Nonvolatile memory program-erase controller

This block sequences program and erase cycles for on-chip nonvolatile storage. Firmware reaches it over a simple register bus with a write strobe, an address, write data and combinational read data. There are three locations. The control register carries the target and mode bits and the start bit. The key location has no storage behind it and is used only to unlock a start. The completion flag register holds the finish interrupt.

To start a cycle, firmware writes 0x55 and then 0xAA to the key location on two consecutive bus writes. Its very next bus write goes to the control register with the start bit and the write-enable bit set. The controller then latches the target space and the mode (program or erase) and raises busy. It drives either the program or the erase strobe toward the array for a fixed number of clock cycles. When the internal timer expires, the start bit falls and the completion flag is set.

There are two reset inputs. `por` clears everything. `rst` clears everything except the error flag. If `rst` arrives while a cycle is running, it sets the error flag, so firmware can later see that the cycle was cut short.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: While busy, `nv_space` shows the target latched at start: 2'b10 (configuration) when control bit 4 was 1, whatever bit 3 says. Otherwise it shows 2'b01 (program memory) when bit 3 was 1, or 2'b00 (data EEPROM) when bit 3 was 0.
- R2: While busy, `nv_erase` is high and `nv_prog` is low if control bit 2 (erase arm) was 1 at start. Otherwise `nv_prog` is high and `nv_erase` is low. Both are low when idle.
- R3: A start write (address 0, bit 0 = 1, while idle) whose bit 1 (write enable) is 0 is ignored. Busy stays low and the error flag (control bit 5) is set.
- R4: A start is accepted only if the two bus writes just before it were 0x55 and then 0xAA to the key location (address 1). Any other order, or any bus write in between, gets the start ignored and sets the error flag.
- R5: Firmware cannot clear the start bit: writing 0 to bit 0 while busy leaves it at 1. Hardware clears it when the cycle completes.
- R6: Busy stays high for exactly PROG_CYCLES clock cycles after the write that was accepted.
- R7: The completion flag (address 2, bit 0, also driven on `nv_done_irq`) is set when a cycle completes. It stays set until firmware writes 0 to that bit. If a completion and a clear land in the same cycle, the flag ends up set.
- R8: The key location always reads as 0x00.
- R9: While busy, writes to control bits 2, 3 and 4 are ignored, and the latched target does not change. Bit 1 (write enable) stays writable.
- R10: When `rst` is asserted during a cycle, busy, the start bit and every other control bit go to 0, and the completion flag goes to 0. The error flag is set. When `rst` is asserted while idle, the error flag keeps its value. `por` clears the error flag as well.
- R11: Writing 1 to control bit 5 clears the error flag.
- R12: After `por`, the control register, the completion flag and all array-side outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; leaves the error flag set if a cycle was running |
| por | input | 1 | Synchronous active-high power-on reset; clears everything |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 key, 2 completion flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| nv_busy | output | 1 | A program or erase cycle is running |
| nv_prog | output | 1 | Program strobe toward the array |
| nv_erase | output | 1 | Erase strobe toward the array |
| nv_space | output | 2 | Latched target space: 00 data, 01 program, 10 configuration |
| nv_done_irq | output | 1 | Completion interrupt flag |

## Verification
Two things can fall on the same clock edge: the timer expiring, which sets the completion flag, and a firmware write that clears that flag. The bench counts edges from the accepted start so that the clear write is sampled on exactly the edge where busy falls. It then requires the flag to read as set, with busy low.

A second collision is a system reset arriving while busy. The bench judges it by the error flag reading 1 while every other control bit reads 0. A third is a failed start attempt combined with a write-one clear of the error flag in the same bus write, where the set must win.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam int DATA_W = 8;

    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_KEY  = 1;
    localparam int unsigned REG_FLAG = 2;

    localparam int B_START = 0;
    localparam int B_WREN  = 1;
    localparam int B_ERASE = 2;
    localparam int B_MSEL  = 3;
    localparam int B_CFG   = 4;
    localparam int B_ERR   = 5;
    localparam int CTRL_USED = 6;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        SPACE_DATA = 2'b00,
        SPACE_PROG = 2'b01,
        SPACE_CFG  = 2'b10
    } space_e;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'b00,
        KEY_HALF = 2'b01,
        KEY_OPEN = 2'b10
    } key_state_e;

    typedef struct packed {
        logic cfg_sel;
        logic mem_sel;
        logic erase_en;
        logic wren;
        logic start;
    } ctrl_t;

    typedef struct packed {
        space_e space;
        logic   erase;
    } job_t;

    function automatic space_e pick_space(input logic cfg, input logic msel);
        if (cfg)
            return SPACE_CFG;
        else if (msel)
            return SPACE_PROG;
        else
            return SPACE_DATA;
    endfunction
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              key_open
);
    localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(REG_KEY);

    key_state_e st;
    logic       key_write;

    assign key_write = we && (addr == KEY_ADDR);

    always_ff @(posedge clk) begin
        if (rst || por) begin
            st <= KEY_IDLE;
        end else if (we) begin
            if (key_write && wdata == KEY_FIRST)
                st <= KEY_HALF;
            else if (key_write && wdata == KEY_SECOND && st == KEY_HALF)
                st <= KEY_OPEN;
            else
                st <= KEY_IDLE;
        end
    end

    assign key_open = (st == KEY_OPEN);

    assert_key_open_R4: assert property (@(posedge clk) disable iff (rst || por)
        (key_write && wdata == KEY_SECOND && st == KEY_HALF) |=> key_open);

    assert_key_drop_R4: assert property (@(posedge clk) disable iff (rst || por)
        (we && !key_write) |=> !key_open);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic load,
    output logic busy,
    output logic finish
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam int LEN_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || por) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign finish = busy && (cnt == '0);

    // independent length monitor for the busy window
    always_ff @(posedge clk) begin
        if (rst || por || !busy)
            run_len <= '0;
        else
            run_len <= run_len + 1'b1;
    end

    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst || por)
        (busy && !finish) |=> busy);

    assert_busy_end_R6: assert property (@(posedge clk) disable iff (rst || por)
        finish |=> !busy);

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst || por)
        finish |-> (run_len == LEN_W'(CYCLES - 1)));
endmodule

// File: rtl/nvm_ctrl_regs.sv
module nvm_ctrl_regs
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CTRL_USED-1:0] wdata,
    input  logic                 key_open,
    input  logic                 busy,
    input  logic                 finish,
    output logic                 load,
    output job_t                 job,
    output logic                 done_flag,
    output logic [DATA_W-1:0]    rdata
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(REG_FLAG);

    ctrl_t ctrl;
    logic  err;
    logic  wr_ctrl, wr_flag, start_req, accept, bad_try, flag_clr;

    assign wr_ctrl   = we && (addr == CTRL_ADDR);
    assign wr_flag   = we && (addr == FLAG_ADDR);
    assign start_req = wr_ctrl && wdata[B_START] && !busy;
    assign accept    = start_req && key_open && wdata[B_WREN];
    assign bad_try   = start_req && !accept;
    assign flag_clr  = wr_flag && !wdata[0];
    assign load      = accept;

    // error flag: separate reset domain, survives rst
    always_ff @(posedge clk) begin
        if (por)
            err <= 1'b0;
        else if (rst) begin
            if (busy)
                err <= 1'b1;
        end else if (bad_try)
            err <= 1'b1;
        else if (wr_ctrl && wdata[B_ERR])
            err <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || por) begin
            ctrl      <= '0;
            job       <= '{space: SPACE_DATA, erase: 1'b0};
            done_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.wren <= wdata[B_WREN];
                if (!busy) begin
                    ctrl.erase_en <= wdata[B_ERASE];
                    ctrl.mem_sel  <= wdata[B_MSEL];
                    ctrl.cfg_sel  <= wdata[B_CFG];
                end
            end
            if (accept) begin
                ctrl.start <= 1'b1;
                job.space  <= pick_space(wdata[B_CFG], wdata[B_MSEL]);
                job.erase  <= wdata[B_ERASE];
            end else if (finish) begin
                ctrl.start <= 1'b0;
            end
            if (finish)
                done_flag <= 1'b1;
            else if (flag_clr)
                done_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR)
            rdata = {2'b00, err, ctrl.cfg_sel, ctrl.mem_sel, ctrl.erase_en,
                     ctrl.wren, ctrl.start};
        else if (addr == FLAG_ADDR)
            rdata = {7'b0, done_flag};
    end

    assert_start_sticky_R5: assert property (@(posedge clk) disable iff (rst || por)
        (ctrl.start && !finish) |=> ctrl.start);

    assert_start_tracks_busy_R5: assert property (@(posedge clk) disable iff (rst || por)
        ctrl.start == busy);

    assert_done_set_R7: assert property (@(posedge clk) disable iff (rst || por)
        finish |=> done_flag);

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst || por)
        (done_flag && !flag_clr) |=> done_flag);

    assert_target_freeze_R9: assert property (@(posedge clk) disable iff (rst || por)
        (busy && !finish) |=> ($stable(job) && $stable(ctrl.mem_sel) &&
                               $stable(ctrl.cfg_sel) && $stable(ctrl.erase_en)));

    assert_reject_nowren_R3: assert property (@(posedge clk) disable iff (rst || por)
        (start_req && !wdata[B_WREN]) |=> (!busy && err));

    assert_err_on_abort_R10: assert property (@(posedge clk) disable iff (por)
        (rst && busy) |=> err);
endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              nv_busy,
    output logic              nv_prog,
    output logic              nv_erase,
    output logic [1:0]        nv_space,
    output logic              nv_done_irq
);
    logic key_open, load, busy, finish, done_flag;
    job_t job;

    nvm_unlock #(.ADDR_W(ADDR_W)) u_unlock (
        .clk(clk), .rst(rst), .por(por),
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .key_open(key_open)
    );

    nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .por(por),
        .load(load), .busy(busy), .finish(finish)
    );

    nvm_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .por(por),
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata[CTRL_USED-1:0]),
        .key_open(key_open), .busy(busy), .finish(finish),
        .load(load), .job(job), .done_flag(done_flag), .rdata(bus_rdata)
    );

    assign nv_busy     = busy;
    assign nv_prog     = busy && !job.erase;
    assign nv_erase    = busy && job.erase;
    assign nv_space    = job.space;
    assign nv_done_irq = done_flag;

    assert_strobe_idle_R2: assert property (@(posedge clk) disable iff (rst || por)
        (!busy && $past(!busy)) |-> (!nv_prog && !nv_erase));
endmodule

// File: tb/nvm_pe_ctrl_tb.sv
module nvm_pe_ctrl_tb;
    localparam int N = 16;
    localparam int AW = 2;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic por = 1'b1;
    logic we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic busy, prog, erase, irq;
    logic [1:0] space;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    nvm_pe_ctrl #(.ADDR_W(AW), .PROG_CYCLES(N)) u_dut (
        .clk(clk), .rst(rst), .por(por), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .nv_busy(busy), .nv_prog(prog),
        .nv_erase(erase), .nv_space(space), .nv_done_irq(irq)
    );

    // vector: {cfg, msel, erase, wren, key_ok, exp_accept, exp_space[1:0]}
    localparam logic [7:0] VEC [7] = '{
        8'b0_0_0_1_1_1_00,
        8'b0_1_0_1_1_1_01,
        8'b1_0_0_1_1_1_10,
        8'b1_1_1_1_1_1_10,
        8'b0_1_1_1_1_1_01,
        8'b0_0_0_0_1_0_00,
        8'b0_1_0_1_0_0_00
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic unlock();
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
    endtask

    task automatic do_por();
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * N && busy; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        por = 1'b0;

        // R12 reset state
        rd(2'd0, v); chk("R12 ctrl after por", v, 8'h00);
        rd(2'd2, v); chk("R12 flag after por", v, 8'h00);
        chk("R12 outputs after por", {busy, prog, erase, space, irq}, 6'b0);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 7; k++) begin
            logic [7:0] e;
            e = VEC[k];
            do_por();
            if (e[3]) unlock();
            wr(2'd0, {3'b000, e[7], e[6], e[5], e[4], 1'b1});
            chk($sformatf("R3/R4 accept vec%0d", k), busy, e[2]);
            if (e[2]) begin
                chk($sformatf("R1 space vec%0d", k), space, e[1:0]);
                chk($sformatf("R2 strobes vec%0d", k), {prog, erase}, {!e[5], e[5]});
                repeat (N - 1) @(negedge clk);
                chk($sformatf("R6 busy last cycle vec%0d", k), busy, 1'b1);
                @(negedge clk);
                chk($sformatf("R6 busy ends vec%0d", k), busy, 1'b0);
                chk($sformatf("R7 done set vec%0d", k), irq, 1'b1);
                rd(2'd0, v);
                chk($sformatf("R5 start cleared vec%0d", k), v[0], 1'b0);
            end else begin
                rd(2'd0, v);
                chk($sformatf("R3/R4 err after reject vec%0d", k), {v[5], v[0]}, 2'b10);
            end
        end

        // R4 interrupted sequence and wrong order
        do_por();
        wr(2'd1, 8'h55); wr(2'd2, 8'h01); wr(2'd1, 8'hAA);
        wr(2'd0, 8'h03);
        chk("R4 interrupted key", busy, 1'b0);
        do_por();
        wr(2'd1, 8'hAA); wr(2'd1, 8'h55);
        wr(2'd0, 8'h03);
        chk("R4 reversed key", busy, 1'b0);
        rd(2'd0, v); chk("R4 err on reversed", v[5], 1'b1);

        // R8 key location reads zero
        wr(2'd1, 8'h55);
        rd(2'd1, v); chk("R8 key reads zero", v, 8'h00);

        // R9 / R5 writes during busy
        do_por();
        unlock();
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h1E);
        rd(2'd0, v); chk("R9 R5 ctrl during busy", v, 8'h03);
        chk("R9 space held", space, 2'b00);
        chk("R9 prog strobe held", {prog, erase}, 2'b10);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R9 wren writable, R5 start held", v, 8'h01);
        wait_idle();

        // R7 hold and clear
        repeat (3) @(negedge clk);
        chk("R7 flag holds", irq, 1'b1);
        wr(2'd2, 8'h01);
        chk("R7 writing 1 keeps flag", irq, 1'b1);
        wr(2'd2, 8'h00);
        chk("R7 clear", irq, 1'b0);

        // R7 collision: clear lands on completion edge
        unlock();
        wr(2'd0, 8'h03);
        repeat (N - 2) @(negedge clk);
        wr(2'd2, 8'h00);
        chk("R7 collision busy", busy, 1'b0);
        chk("R7 collision flag set", irq, 1'b1);

        // R10 reset during busy
        unlock();
        wr(2'd0, 8'h0B);
        repeat (3) @(negedge clk);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R10 busy cleared", {busy, prog, erase, irq}, 4'b0);
        rd(2'd0, v); chk("R10 err only", v, 8'h20);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(2'd0, v); chk("R10 idle rst keeps err", v, 8'h20);

        // R11 write-one clear, and set winning over clear
        wr(2'd0, 8'h20);
        rd(2'd0, v); chk("R11 err cleared", v[5], 1'b0);
        wr(2'd0, 8'h21);
        rd(2'd0, v); chk("R11 bad start beats clear", v[5], 1'b1);

        // R10 por clears err
        do_por();
        rd(2'd0, v); chk("R10 por clears err", v, 8'h00);

        summary();
    end
endmodule